// File: doc/BRIEF.md
# Cross-Clock Mailbox Register

This block carries a single data word from a producer clock domain to a consumer clock domain without passing it through the FIFO. The producer writes the word when its mailbox select is high. An active-low "mail waiting" flag then falls. It stays low until the consumer has taken the word, and every producer write in that window is dropped. The consumer sees its own copy of the flag. A read with its mailbox select high returns that flag high, and the release then travels back to the producer.

Each direction of the handshake uses a toggle register and a two-flop synchronizer, so the producer and consumer clocks need no fixed relation. On the consumer side a registered multiplexer chooses what drives the outputs: the mailbox word when the mailbox select is high, the FIFO output register when it is low. A master reset samples a lane-width input that picks the full port width or the lower half of it. A partial reset drops pending mail but keeps that choice.

Top module: `xclk_mailbox`

## Requirements
- R1: A producer clock edge with `wr_en` and `wr_mbox_sel` high while `wr_mail_n` is high stores `wr_data` and drives `wr_mail_n` low after that edge.
- R2: While `wr_mail_n` is low, producer writes are dropped and the stored word is unchanged, so the consumer later reads the first word.
- R3: After an accepted write, `rd_mail_n` goes low within three consumer clock cycles.
- R4: A consumer edge with `rd_en` and `rd_mbox_sel` high while `rd_mail_n` is low drives `rd_mail_n` high after that edge, and `wr_mail_n` returns high within three producer cycles.
- R5: A consumer edge with `rd_en` low, or with `rd_mbox_sel` low, leaves a pending `rd_mail_n` low.
- R6: `rd_data` is registered. One consumer edge after `rd_mbox_sel` is high it holds the mailbox word, and one edge after it is low it holds `fifo_q`.
- R7: Master reset (`wr_mrst` and `rd_mrst`, synchronous, active high) drives both flags high and clears `rd_data` and the mailbox word to zero. It also latches `cfg_half`: 1 keeps only the lower `DATA_W/2` bits of written words (upper bits stored as zero), 0 keeps all `DATA_W` bits.
- R8: Partial reset (`wr_prst` and `rd_prst`) drives both flags high and clears `rd_data`. The lane width latched by the last master reset is kept.
- R9: A consumer mailbox read while `rd_mail_n` is high changes neither flag, and the next write/read exchange works normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Producer clock |
| wr_mrst | input | 1 | Producer-side master reset, synchronous, active high |
| wr_prst | input | 1 | Producer-side partial reset, synchronous, active high |
| cfg_half | input | 1 | Lane width select, sampled during master reset (1 = half width) |
| wr_en | input | 1 | Producer write strobe |
| wr_mbox_sel | input | 1 | Producer mailbox select |
| wr_data | input | DATA_W | Word to post |
| wr_mail_n | output | 1 | Mail waiting, active low, producer domain |
| rd_clk | input | 1 | Consumer clock |
| rd_mrst | input | 1 | Consumer-side master reset, synchronous, active high |
| rd_prst | input | 1 | Consumer-side partial reset, synchronous, active high |
| rd_en | input | 1 | Consumer read strobe |
| rd_mbox_sel | input | 1 | Consumer mailbox select, also steers `rd_data` |
| fifo_q | input | DATA_W | FIFO output register data |
| rd_data | output | DATA_W | Registered consumer output |
| rd_mail_n | output | 1 | Mail waiting, active low, consumer domain |

## Verification
The flag of the side that caused an event changes one edge after it: `wr_mail_n` after the write edge, `rd_mail_n` after the read edge. `rd_data` also follows the select one consumer edge later. The bench therefore samples these at the next falling edge of the clock concerned. The flag in the other domain is due within three of that domain's cycles, because of the two synchronizer flops and the unknown phase between the clocks. For these the bench counts falling edges of the receiving clock until the flag moves, and fails when the count exceeds three. The two clocks are offset so that no edge of one coincides with an edge of the other.

// File: rtl/xmb_pkg.sv
package xmb_pkg;

  typedef enum logic {
    LANE_FULL = 1'b0,
    LANE_HALF = 1'b1
  } lane_mode_e;

  typedef enum logic [1:0] {
    RST_NONE    = 2'd0,
    RST_PARTIAL = 2'd1,
    RST_MASTER  = 2'd2
  } rst_kind_e;

  // master reset wins over partial reset
  function automatic rst_kind_e decode_rst(input logic master, input logic partial);
    if (master)       return RST_MASTER;
    else if (partial) return RST_PARTIAL;
    else              return RST_NONE;
  endfunction

endpackage

// File: rtl/xmb_toggle_sync.sv
module xmb_toggle_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= d;
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];

endmodule

// File: rtl/xmb_wr_side.sv
module xmb_wr_side
  import xmb_pkg::*;
#(
  parameter int DATA_W = 18
) (
  input  logic              clk,
  input  logic              mrst,
  input  logic              prst,
  input  logic              cfg_half,
  input  logic              en,
  input  logic              sel,
  input  logic [DATA_W-1:0] din,
  input  logic              clr_seen,
  output logic              set_tgl,
  output logic [DATA_W-1:0] mail_q,
  output logic              mail_n
);

  localparam int HALF_W = DATA_W / 2;

  lane_mode_e        mode_q;
  logic              set_q;
  logic              pending;
  logic              accept;
  logic [DATA_W-1:0] fitted;

  assign pending = set_q ^ clr_seen;
  assign accept  = en & sel & ~pending;

  always_comb begin
    fitted = din;
    if (mode_q == LANE_HALF) fitted[DATA_W-1:HALF_W] = '0;
  end

  always_ff @(posedge clk) begin
    case (decode_rst(mrst, prst))
      RST_MASTER: begin
        mode_q <= lane_mode_e'(cfg_half);
        set_q  <= 1'b0;
        mail_q <= '0;
      end
      RST_PARTIAL: begin
        set_q <= 1'b0;
      end
      default: begin
        if (accept) begin
          set_q  <= ~set_q;
          mail_q <= fitted;
        end
      end
    endcase
  end

  assign set_tgl = set_q;
  assign mail_n  = ~pending;

endmodule

// File: rtl/xmb_rd_side.sv
module xmb_rd_side
  import xmb_pkg::*;
#(
  parameter int DATA_W = 18
) (
  input  logic              clk,
  input  logic              mrst,
  input  logic              prst,
  input  logic              en,
  input  logic              sel,
  input  logic [DATA_W-1:0] fifo_q,
  input  logic [DATA_W-1:0] mail_q,
  input  logic              set_seen,
  output logic              clr_tgl,
  output logic [DATA_W-1:0] dout,
  output logic              mail_n
);

  logic clr_q;
  logic pending;
  logic accept;

  assign pending = set_seen ^ clr_q;
  assign accept  = en & sel & pending;

  always_ff @(posedge clk) begin
    if (decode_rst(mrst, prst) != RST_NONE) begin
      clr_q <= 1'b0;
      dout  <= '0;
    end else begin
      if (accept) clr_q <= ~clr_q;
      dout <= sel ? mail_q : fifo_q;
    end
  end

  assign clr_tgl = clr_q;
  assign mail_n  = ~pending;

endmodule

// File: rtl/xclk_mailbox.sv
module xclk_mailbox #(
  parameter int DATA_W      = 18,
  parameter int SYNC_STAGES = 2
) (
  input  logic              wr_clk,
  input  logic              wr_mrst,
  input  logic              wr_prst,
  input  logic              cfg_half,
  input  logic              wr_en,
  input  logic              wr_mbox_sel,
  input  logic [DATA_W-1:0] wr_data,
  output logic              wr_mail_n,
  input  logic              rd_clk,
  input  logic              rd_mrst,
  input  logic              rd_prst,
  input  logic              rd_en,
  input  logic              rd_mbox_sel,
  input  logic [DATA_W-1:0] fifo_q,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_mail_n
);

  logic              wr_any_rst;
  logic              rd_any_rst;
  logic              set_tgl;
  logic              clr_tgl;
  logic              set_seen;
  logic              clr_seen;
  logic [DATA_W-1:0] mail_q;

  assign wr_any_rst = wr_mrst | wr_prst;
  assign rd_any_rst = rd_mrst | rd_prst;

  xmb_wr_side #(.DATA_W(DATA_W)) u_wr (
    .clk      (wr_clk),
    .mrst     (wr_mrst),
    .prst     (wr_prst),
    .cfg_half (cfg_half),
    .en       (wr_en),
    .sel      (wr_mbox_sel),
    .din      (wr_data),
    .clr_seen (clr_seen),
    .set_tgl  (set_tgl),
    .mail_q   (mail_q),
    .mail_n   (wr_mail_n)
  );

  xmb_toggle_sync #(.STAGES(SYNC_STAGES)) u_set_sync (
    .clk (rd_clk),
    .rst (rd_any_rst),
    .d   (set_tgl),
    .q   (set_seen)
  );

  xmb_toggle_sync #(.STAGES(SYNC_STAGES)) u_clr_sync (
    .clk (wr_clk),
    .rst (wr_any_rst),
    .d   (clr_tgl),
    .q   (clr_seen)
  );

  xmb_rd_side #(.DATA_W(DATA_W)) u_rd (
    .clk      (rd_clk),
    .mrst     (rd_mrst),
    .prst     (rd_prst),
    .en       (rd_en),
    .sel      (rd_mbox_sel),
    .fifo_q   (fifo_q),
    .mail_q   (mail_q),
    .set_seen (set_seen),
    .clr_tgl  (clr_tgl),
    .dout     (rd_data),
    .mail_n   (rd_mail_n)
  );

endmodule

// File: rtl/xmb_checker.sv
module xmb_checker #(
  parameter int DATA_W = 18
) (
  input logic              wr_clk,
  input logic              wr_mrst,
  input logic              wr_prst,
  input logic              wr_en,
  input logic              wr_mbox_sel,
  input logic              wr_mail_n,
  input logic              rd_clk,
  input logic              rd_mrst,
  input logic              rd_prst,
  input logic              rd_en,
  input logic              rd_mbox_sel,
  input logic [DATA_W-1:0] fifo_q,
  input logic [DATA_W-1:0] rd_data,
  input logic              rd_mail_n,
  input logic [DATA_W-1:0] mail_q
);

  assert_write_sets_flag_R1: assert property (@(posedge wr_clk) disable iff (wr_mrst || wr_prst)
    (wr_en && wr_mbox_sel && wr_mail_n) |=> !wr_mail_n);

  assert_blocked_write_keeps_word_R2: assert property (@(posedge wr_clk) disable iff (wr_mrst || wr_prst)
    !wr_mail_n |=> $stable(mail_q));

  assert_read_clears_flag_R4: assert property (@(posedge rd_clk) disable iff (rd_mrst || rd_prst)
    (rd_en && rd_mbox_sel && !rd_mail_n) |=> rd_mail_n);

  assert_no_clear_without_read_R5: assert property (@(posedge rd_clk) disable iff (rd_mrst || rd_prst)
    (!rd_mail_n && !(rd_en && rd_mbox_sel)) |=> !rd_mail_n);

  assert_mux_mailbox_R6: assert property (@(posedge rd_clk) disable iff (rd_mrst || rd_prst)
    rd_mbox_sel |=> (rd_data == $past(mail_q)));

  assert_mux_fifo_R6: assert property (@(posedge rd_clk) disable iff (rd_mrst || rd_prst)
    !rd_mbox_sel |=> (rd_data == $past(fifo_q)));

  assert_rd_reset_clears_R8: assert property (@(posedge rd_clk)
    (rd_mrst || rd_prst) |=> (rd_mail_n && rd_data == '0));

  assert_wr_reset_clears_R7: assert property (@(posedge wr_clk)
    (wr_mrst || wr_prst) |=> wr_mail_n);

endmodule

bind xclk_mailbox xmb_checker #(.DATA_W(DATA_W)) u_xmb_checker (
  .wr_clk      (wr_clk),
  .wr_mrst     (wr_mrst),
  .wr_prst     (wr_prst),
  .wr_en       (wr_en),
  .wr_mbox_sel (wr_mbox_sel),
  .wr_mail_n   (wr_mail_n),
  .rd_clk      (rd_clk),
  .rd_mrst     (rd_mrst),
  .rd_prst     (rd_prst),
  .rd_en       (rd_en),
  .rd_mbox_sel (rd_mbox_sel),
  .fifo_q      (fifo_q),
  .rd_data     (rd_data),
  .rd_mail_n   (rd_mail_n),
  .mail_q      (mail_q)
);

// File: tb/xclk_mailbox_bench.sv
`timescale 1ns/100ps
module xclk_mailbox_bench;

  localparam int DW = 18;
  localparam int HW = DW / 2;

  logic wr_clk = 1'b0;
  logic rd_clk = 1'b0;
  logic wr_mrst = 1'b1, wr_prst = 1'b0, cfg_half = 1'b0;
  logic wr_en = 1'b0, wr_mbox_sel = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic rd_mrst = 1'b1, rd_prst = 1'b0, rd_en = 1'b0, rd_mbox_sel = 1'b0;
  logic [DW-1:0] fifo_q = '0;
  logic wr_mail_n, rd_mail_n;
  logic [DW-1:0] rd_data;

  int checks = 0;
  int fails  = 0;

  always #2 wr_clk = ~wr_clk;
  initial begin
    #0.5;
    forever #3 rd_clk = ~rd_clk;
  end

  xclk_mailbox #(.DATA_W(DW)) u_xclk_mailbox (
    .wr_clk(wr_clk), .wr_mrst(wr_mrst), .wr_prst(wr_prst), .cfg_half(cfg_half),
    .wr_en(wr_en), .wr_mbox_sel(wr_mbox_sel), .wr_data(wr_data), .wr_mail_n(wr_mail_n),
    .rd_clk(rd_clk), .rd_mrst(rd_mrst), .rd_prst(rd_prst), .rd_en(rd_en),
    .rd_mbox_sel(rd_mbox_sel), .fifo_q(fifo_q), .rd_data(rd_data), .rd_mail_n(rd_mail_n)
  );

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] lane(input logic half, input logic [DW-1:0] d);
    return half ? (d & DW'((1 << HW) - 1)) : d;
  endfunction

  task automatic do_reset(input bit master, input bit half, input string tag);
    @(negedge wr_clk);
    cfg_half = half;
    if (master) begin wr_mrst = 1'b1; rd_mrst = 1'b1; end
    else        begin wr_prst = 1'b1; rd_prst = 1'b1; end
    repeat (8) @(negedge wr_clk);
    @(negedge rd_clk);
    chk({tag, " rd_mail_n in reset"}, DW'(rd_mail_n), DW'(1));
    chk({tag, " rd_data in reset"}, rd_data, '0);
    @(negedge wr_clk);
    chk({tag, " wr_mail_n in reset"}, DW'(wr_mail_n), DW'(1));
    wr_mrst = 1'b0; rd_mrst = 1'b0; wr_prst = 1'b0; rd_prst = 1'b0;
    cfg_half = ~half;
  endtask

  task automatic write_mb(input logic [DW-1:0] d);
    @(negedge wr_clk);
    wr_en = 1'b1; wr_mbox_sel = 1'b1; wr_data = d;
    @(negedge wr_clk);
    wr_en = 1'b0; wr_mbox_sel = 1'b0;
  endtask

  task automatic wait_rd_flag(input string tag);
    int n = 0;
    while (rd_mail_n !== 1'b0 && n < 6) begin @(negedge rd_clk); n++; end
    chk({tag, " rd_mail_n low within 3 cycles"}, DW'(rd_mail_n == 1'b0 && n <= 3), DW'(1));
  endtask

  task automatic wait_wr_clear(input string tag);
    int n = 0;
    while (wr_mail_n !== 1'b1 && n < 6) begin @(negedge wr_clk); n++; end
    chk({tag, " wr_mail_n high within 3 cycles"}, DW'(wr_mail_n == 1'b1 && n <= 3), DW'(1));
  endtask

  task automatic read_mb(input logic [DW-1:0] exp, input string tag);
    @(negedge rd_clk);
    rd_en = 1'b1; rd_mbox_sel = 1'b1;
    @(negedge rd_clk);
    rd_en = 1'b0; rd_mbox_sel = 1'b0;
    chk({tag, " rd_data mailbox word"}, rd_data, exp);
    chk({tag, " rd_mail_n high after read"}, DW'(rd_mail_n), DW'(1));
  endtask

  initial begin
    #500000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    do_reset(1'b1, 1'b0, "R7 master full");

    for (int i = 0; i < 32; i++) begin
      logic [DW-1:0] d;
      d = DW'((i * 9973 + 17 * i * i + 5) % (1 << DW));
      fifo_q = d ^ 18'h2AAAA;
      write_mb(d);
      chk("R1 wr_mail_n low after write", DW'(wr_mail_n), DW'(0));
      wait_rd_flag("R3");
      if (i % 4 == 1) begin
        write_mb(~d);
        chk("R2 wr_mail_n stays low on blocked write", DW'(wr_mail_n), DW'(0));
      end
      if (i % 4 == 2) begin
        @(negedge rd_clk); rd_en = 1'b0; rd_mbox_sel = 1'b1;
        @(negedge rd_clk);
        chk("R5 no clear without rd_en", DW'(rd_mail_n), DW'(0));
        chk("R6 select high shows mailbox", rd_data, d);
        rd_en = 1'b1; rd_mbox_sel = 1'b0;
        @(negedge rd_clk);
        rd_en = 1'b0;
        chk("R5 no clear without select", DW'(rd_mail_n), DW'(0));
        chk("R6 select low shows fifo_q", rd_data, fifo_q);
      end
      read_mb(d, "R2 R4");
      @(negedge rd_clk);
      chk("R6 fifo_q after select drops", rd_data, fifo_q);
      wait_wr_clear("R4");
    end

    // R9: mailbox read with nothing pending
    @(negedge rd_clk); rd_en = 1'b1; rd_mbox_sel = 1'b1;
    @(negedge rd_clk); rd_en = 1'b0; rd_mbox_sel = 1'b0;
    chk("R9 rd_mail_n stays high on empty read", DW'(rd_mail_n), DW'(1));
    repeat (4) @(negedge wr_clk);
    chk("R9 wr_mail_n stays high on empty read", DW'(wr_mail_n), DW'(1));
    write_mb(18'h1234B);
    chk("R9 write after empty read", DW'(wr_mail_n), DW'(0));
    wait_rd_flag("R9");
    read_mb(18'h1234B, "R9");
    wait_wr_clear("R9");

    // R7: half lane, and master reset clears the stored word
    do_reset(1'b1, 1'b1, "R7 master half");
    @(negedge rd_clk); rd_mbox_sel = 1'b1;
    @(negedge rd_clk); rd_mbox_sel = 1'b0;
    chk("R7 mailbox word cleared by master reset", rd_data, '0);
    write_mb(18'h3FFFF);
    wait_rd_flag("R7");
    read_mb(lane(1'b1, 18'h3FFFF), "R7 half lane");
    wait_wr_clear("R7");

    // R8: partial reset drops pending mail, keeps half lane
    write_mb(18'h2C3A5);
    wait_rd_flag("R8 pending");
    do_reset(1'b0, 1'b0, "R8 partial");
    write_mb(18'h3FFFF);
    chk("R8 write accepted after partial reset", DW'(wr_mail_n), DW'(0));
    wait_rd_flag("R8");
    read_mb(lane(1'b1, 18'h3FFFF), "R8 lane kept");
    wait_wr_clear("R8");

    // R7: back to full lane
    do_reset(1'b1, 1'b0, "R7 master full again");
    write_mb(18'h3FFFF);
    wait_rd_flag("R7");
    read_mb(18'h3FFFF, "R7 full lane");
    wait_wr_clear("R7");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule